// File: doc/BRIEF.md
# Batched GF(2^131) Inverter Front End

This block turns a batch of N nonzero elements of the binary field GF(2^131) into their N inverses while calling on a field inverter only once. Elements arrive one per valid/ready handshake. As each one is accepted, the block multiplies it into a running product and stores that prefix product in a local element RAM. After the last element it sends the full product to an external inverter over a request/response pair. Once the inverse comes back, it walks the stored prefix products from the highest index down to the lowest. At each step two multiplications give one inverse and update the running inverse.

All arithmetic runs on one internal bit-serial multiplier, with one product in flight at a time. Apart from the single external inversion, a batch costs 3·(N−1) multiplications. Recovered inverses overwrite the prefix-product slots they no longer need. When the batch is complete they are read out in input order. A new batch is accepted only after the last inverse of the previous one has been taken.

Top module: `batch_inv`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and `inv_req_valid` is 0.
- R2: Exactly N elements are accepted per batch. `in_ready` is 0 in the cycle after any element other than the first of a batch is accepted, and stays 0 from the last acceptance until the last result of the batch has been taken. It is 1 again in the cycle after that last output handshake.
- R3: Per batch, exactly one inverter request is made, after the Nth element. `inv_req_valid` is high for a single cycle and `inv_req_data` is then the product of all N elements of the batch.
- R4: The k-th output of a batch (k counted from 0) equals the inverse of the k-th accepted element of that batch, so each output times its element equals 1.
- R5: Elements are 131-bit polynomial-basis values, with bit i the coefficient of x^i. Products are reduced modulo x^131 + x^13 + x^2 + x + 1, including operands with bit 130 set and the all-ones element.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R7: Each forward multiplication keeps `in_ready` low for at most W+3 cycles, W being 131. From the cycle the inverter response is taken to the first `out_valid`, at most (N−1)·(2W+8)+8 cycles pass. N may be set to 32, 48 or 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Block can accept an element |
| in_data | input | 131 | Field element to invert |
| inv_req_valid | output | 1 | One-cycle request to the external inverter |
| inv_req_data | output | 131 | Product of the whole batch, to be inverted |
| inv_rsp_valid | input | 1 | Inverter response present (one cycle) |
| inv_rsp_data | input | 131 | Inverse of the requested product |
| out_valid | output | 1 | Inverse available |
| out_ready | input | 1 | Consumer takes the inverse |
| out_data | output | 131 | Inverse, in input order |

## Verification
Two events can fall in the same cycle, and the bench provokes both. The first is the inverter's answer landing in the very cycle the request pulse ends. One batch uses a zero-delay inverter model, so the response capture overlaps the drop of `inv_req_valid`; another batch uses a long delay. The second is a consumer stall in the cycle a result first becomes valid. The output handshake is driven always-ready, alternating and irregular, and held data is compared across each stall. Every result is judged against an inverse computed independently in the bench, and also by multiplying it back with its element.

// File: rtl/binv_pkg.sv
package binv_pkg;
  // field width and the low terms of the reduction polynomial (x^13+x^2+x+1)
  localparam int FW = 131;
  localparam logic [FW-1:0] RED_TAIL = FW'((1 << 13) | (1 << 2) | (1 << 1) | 1);

  typedef logic [FW-1:0] felem_t;

  typedef enum logic [3:0] {
    ST_LOAD, ST_FMUL, ST_IWAIT, ST_BRD, ST_BM1, ST_BW1,
    ST_BM2, ST_BW2, ST_ORD, ST_OLD, ST_OHS
  } bstate_t;

  // multiply by x and reduce
  function automatic felem_t times_x(input felem_t v);
    return {v[FW-2:0], 1'b0} ^ (v[FW-1] ? RED_TAIL : '0);
  endfunction
endpackage

// File: rtl/binv_gfmul.sv
module binv_gfmul
  import binv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  felem_t opa,
  input  felem_t opb,
  output logic   done,
  output felem_t result
);
  localparam int CW = $clog2(FW);

  felem_t a_q, b_q, acc;
  logic [CW-1:0] cnt;
  logic busy;

  // MSB-first shift-and-add: one coefficient of opb per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      acc  <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        a_q  <= opa;
        b_q  <= opb;
        acc  <= '0;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        acc <= times_x(acc) ^ (b_q[FW-1] ? a_q : '0);
        b_q <= b_q << 1;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(FW - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign result = acc;
endmodule

// File: rtl/binv_ram.sv
module binv_ram #(
  parameter int DW    = 131,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/batch_inv.sv
module batch_inv
  import binv_pkg::*;
#(
  parameter int N = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [FW-1:0] in_data,
  output logic          inv_req_valid,
  output logic [FW-1:0] inv_req_data,
  input  logic          inv_rsp_valid,
  input  logic [FW-1:0] inv_rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [FW-1:0] out_data
);
  localparam int AW = $clog2(N);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  bstate_t state;
  logic [AW-1:0] k_idx, i_idx, j_idx;
  felem_t prod, u_acc;

  logic in_fire;
  logic mul_start, mul_done;
  felem_t mul_a, mul_b, mul_res;
  logic c_we, c_re, a_we, a_re;
  logic [AW-1:0] c_waddr, c_raddr;
  felem_t c_wdata, c_rd, a_rd;

  assign in_ready = (state == ST_LOAD);
  assign in_fire  = in_valid && in_ready;
  assign inv_req_data = prod;

  // operand and start selection for the shared multiplier
  always_comb begin
    mul_start = 1'b0;
    mul_a = u_acc;
    mul_b = c_rd;
    unique case (state)
      ST_LOAD: begin
        mul_start = in_fire && (k_idx != '0);
        mul_a = prod;
        mul_b = in_data;
      end
      ST_BM1: mul_start = 1'b1;
      ST_BM2: begin
        mul_start = 1'b1;
        mul_b = a_rd;
      end
      default: ;
    endcase
  end

  // prefix products, later overwritten by the recovered inverses
  always_comb begin
    c_we    = 1'b0;
    c_waddr = '0;
    c_wdata = mul_res;
    unique case (state)
      ST_LOAD: begin
        c_we    = in_fire && (k_idx == '0);
        c_wdata = in_data;
      end
      ST_FMUL: begin
        c_we    = mul_done;
        c_waddr = k_idx;
      end
      ST_BW1: begin
        c_we    = mul_done;
        c_waddr = i_idx;
      end
      ST_BW2: c_we = mul_done && (i_idx == AW'(1));
      default: ;
    endcase
  end

  assign c_re    = (state == ST_BRD) || (state == ST_ORD);
  assign c_raddr = (state == ST_BRD) ? i_idx - 1'b1 : j_idx;
  assign a_we    = in_fire;
  assign a_re    = (state == ST_BRD);

  binv_ram #(.DW(FW), .DEPTH(N)) u_cram (
    .clk(clk), .we(c_we), .waddr(c_waddr), .wdata(c_wdata),
    .re(c_re), .raddr(c_raddr), .rdata(c_rd)
  );

  binv_ram #(.DW(FW), .DEPTH(N)) u_aram (
    .clk(clk), .we(a_we), .waddr(k_idx), .wdata(in_data),
    .re(a_re), .raddr(i_idx), .rdata(a_rd)
  );

  binv_gfmul u_mul (
    .clk(clk), .rst(rst), .start(mul_start), .opa(mul_a), .opb(mul_b),
    .done(mul_done), .result(mul_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_LOAD;
      k_idx         <= '0;
      i_idx         <= '0;
      j_idx         <= '0;
      prod          <= '0;
      u_acc         <= '0;
      inv_req_valid <= 1'b0;
      out_valid     <= 1'b0;
      out_data      <= '0;
    end else begin
      inv_req_valid <= 1'b0;
      unique case (state)
        ST_LOAD: if (in_fire) begin
          if (k_idx == '0) begin
            prod  <= in_data;
            k_idx <= k_idx + 1'b1;
          end else begin
            state <= ST_FMUL;
          end
        end
        ST_FMUL: if (mul_done) begin
          prod <= mul_res;
          if (k_idx == LAST) begin
            inv_req_valid <= 1'b1;
            state         <= ST_IWAIT;
          end else begin
            k_idx <= k_idx + 1'b1;
            state <= ST_LOAD;
          end
        end
        ST_IWAIT: if (inv_rsp_valid) begin
          u_acc <= inv_rsp_data;
          i_idx <= LAST;
          state <= ST_BRD;
        end
        ST_BRD: state <= ST_BM1;
        ST_BM1: state <= ST_BW1;
        ST_BW1: if (mul_done) state <= ST_BM2;
        ST_BM2: state <= ST_BW2;
        ST_BW2: if (mul_done) begin
          u_acc <= mul_res;
          if (i_idx == AW'(1)) begin
            j_idx <= '0;
            state <= ST_ORD;
          end else begin
            i_idx <= i_idx - 1'b1;
            state <= ST_BRD;
          end
        end
        ST_ORD: state <= ST_OLD;
        ST_OLD: begin
          out_data  <= c_rd;
          out_valid <= 1'b1;
          state     <= ST_OHS;
        end
        ST_OHS: if (out_ready) begin
          out_valid <= 1'b0;
          if (j_idx == LAST) begin
            k_idx <= '0;
            state <= ST_LOAD;
          end else begin
            j_idx <= j_idx + 1'b1;
            state <= ST_ORD;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/batch_inv_chk.sv
module batch_inv_chk
  import binv_pkg::*;
#(
  parameter int N = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          inv_req_valid,
  input logic [FW-1:0] inv_req_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [FW-1:0] out_data
);
  localparam int CNW = $clog2(N + 1);
  logic [CNW-1:0] taken;

  always_ff @(posedge clk) begin
    if (rst) taken <= '0;
    else if (inv_req_valid) taken <= '0;
    else if (in_valid && in_ready) taken <= taken + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) $fell(rst) |-> in_ready && !out_valid && !inv_req_valid)
    else $error("R1 outputs not idle after reset");

  p_req_after_n_r2: assert property (@(posedge clk) disable iff (rst) inv_req_valid |-> taken == CNW'(N))
    else $error("R2 request without exactly N accepted elements");

  p_no_accept_out_r2: assert property (@(posedge clk) disable iff (rst) out_valid |-> !in_ready)
    else $error("R2 input open while results pending");

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst) inv_req_valid |=> !inv_req_valid)
    else $error("R3 request longer than one cycle");

  p_req_nonzero_r3: assert property (@(posedge clk) disable iff (rst) inv_req_valid |-> inv_req_data != '0)
    else $error("R3 zero product requested");

  p_hold_r6: assert property (@(posedge clk) disable iff (rst) out_valid && !out_ready |=> out_valid && $stable(out_data))
    else $error("R6 output changed under stall");
endmodule

bind batch_inv batch_inv_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .inv_req_valid(inv_req_valid), .inv_req_data(inv_req_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/batch_inv_test.sv
`timescale 1ns/1ps
module batch_inv_test;
  localparam int W = 131;
  localparam int N = 32;
  localparam logic [W-1:0] ONE = W'(1);

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [W-1:0] in_data = '0;
  logic inv_req_valid;
  logic [W-1:0] inv_req_data;
  logic inv_rsp_valid = 1'b0;
  logic [W-1:0] inv_rsp_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [W-1:0] out_data;

  int checks = 0, failures = 0;
  int outs_seen = 0, req_cnt = 0;
  int inv_delay = 0, ready_mode = 0;
  logic [W-1:0] exp_prod;
  logic [W-1:0] q_inv[$];
  logic [W-1:0] q_elem[$];

  always #5 clk = ~clk;

  batch_inv #(.N(N)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .inv_req_valid(inv_req_valid), .inv_req_data(inv_req_data),
    .inv_rsp_valid(inv_rsp_valid), .inv_rsp_data(inv_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // LSB-first field product, reduced by x^131+x^13+x^2+x+1 (R5)
  function automatic logic [W-1:0] fmul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r = '0;
    logic [W-1:0] s = a;
    for (int n = 0; n < W; n++) begin
      if (b[n]) r = r ^ s;
      s = {s[W-2:0], 1'b0} ^ (s[W-1] ? W'(14'h2007) : '0);
    end
    return r;
  endfunction

  // a^(2^131-2)
  function automatic logic [W-1:0] finv(input logic [W-1:0] a);
    logic [W-1:0] r = a;
    for (int n = 0; n < W - 2; n++) r = fmul(fmul(r, r), a);
    return fmul(r, r);
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] make_elem(input int b, input int k);
    logic [W-1:0] e;
    if (b == 0 && k == 0) return ONE;
    if (b == 0 && k == 1) return ONE << (W - 1);
    if (b == 0 && k == 2) return '1;
    if (b == 0 && k == 3) return (ONE << (W - 1)) | ONE;
    e = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()} >> 29;
    if (e == '0) e = ONE;
    return e;
  endfunction

  // driver: pushes expected items and feeds one batch
  task automatic run_batch(input int b);
    logic [W-1:0] e;
    int lowc;
    exp_prod = ONE;
    for (int k = 0; k < N; k++) begin
      e = make_elem(b, k);
      exp_prod = fmul(exp_prod, e);
      q_elem.push_back(e);
      q_inv.push_back(finv(e));
    end
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = q_elem[q_elem.size() - N + k];
      @(posedge clk);
      #1 in_valid = 1'b0;
      in_data = '0;
      if (k > 0 && k < N - 1) begin
        @(negedge clk);
        check(!in_ready, "R2 in_ready low during product", W'(in_ready), '0);
        lowc = 1;
        while (!in_ready && lowc < 1000) begin
          @(negedge clk);
          if (!in_ready) lowc++;
        end
        check(lowc <= W + 3, "R7 forward step length", W'(lowc), W'(W + 3));
      end
    end
    while (outs_seen < (b + 1) * N) @(negedge clk);
    @(negedge clk);
    check(req_cnt == b + 1, "R3 one request per batch", W'(req_cnt), W'(b + 1));
    check(in_ready, "R2 input reopens after drain", W'(in_ready), ONE);
  endtask

  // external inverter model
  initial begin
    int lat;
    forever begin
      @(negedge clk);
      if (!rst && inv_req_valid) begin
        req_cnt++;
        check(inv_req_data == exp_prod, "R3 request carries batch product", inv_req_data, exp_prod);
        repeat (inv_delay) @(negedge clk);
        inv_rsp_data  = finv(inv_req_data);
        inv_rsp_valid = 1'b1;
        @(negedge clk);
        inv_rsp_valid = 1'b0;
        check(!inv_req_valid, "R3 request is a single pulse", W'(inv_req_valid), '0);
        lat = 1;
        while (!out_valid && lat < 20000) begin
          @(negedge clk);
          lat++;
        end
        check(lat <= (N - 1) * (2 * W + 8) + 8, "R7 backward pass length", W'(lat), W'((N - 1) * (2 * W + 8) + 8));
      end
    end
  end

  // monitor: pops expected inverses on each output handshake
  initial begin
    bit stalled = 1'b0;
    logic [W-1:0] held = '0;
    logic [W-1:0] ex, el;
    int tog = 0;
    forever begin
      @(negedge clk);
      tog++;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = tog[0];
        default: out_ready = ($urandom() % 4) != 0;
      endcase
      if (stalled) check(out_valid && out_data == held, "R6 output held under stall", out_data, held);
      stalled = 1'b0;
      if (out_valid && !out_ready) begin
        stalled = 1'b1;
        held = out_data;
      end
      if (out_valid && out_ready) begin
        ex = q_inv.pop_front();
        el = q_elem.pop_front();
        check(out_data == ex, "R4 inverse in input order", out_data, ex);
        check(fmul(out_data, el) == ONE, "R5 element times result is one", fmul(out_data, el), ONE);
        check(!in_ready, "R2 input closed while draining", W'(in_ready), '0);
        outs_seen++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(in_ready, "R1 in_ready after reset", W'(in_ready), ONE);
    check(!out_valid, "R1 out_valid after reset", W'(out_valid), '0);
    check(!inv_req_valid, "R1 no request after reset", W'(inv_req_valid), '0);
    inv_delay = 0;  ready_mode = 0;
    run_batch(0);
    inv_delay = 25; ready_mode = 1;
    run_batch(1);
    inv_delay = 3;  ready_mode = 2;
    run_batch(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule